// File: doc/BRIEF.md
# Crossbar Slave-Port Arbitration Configuration Registers

This block holds the arbitration settings of one slave port of a multi-master crossbar. A priority register keeps one 3-bit rank per master, where a smaller value wins. A control register keeps four settings: a sticky write lock, a flag that drops the halt request to the lowest rank for initial arbitration, a parking mode, and the master to park on. The stored settings drive the port's arbiter all the time through plain output pins.

Software reaches the registers through a simple register bus. A request is a single-cycle strobe on `bus_rd` or `bus_wr`, with address, size, privilege flag and write data. The bus never stalls: there is no ready signal, and a request is taken in every cycle in which a strobe is high. Exactly one cycle later the block raises `rsp_valid` for one cycle, together with read data and `rsp_err`. The response cannot be held back, so the requester must sample it in that cycle.

The block rejects any access that breaks the privilege or width rules, hits an unmapped offset, would give two masters the same rank, selects the reserved parking mode, or writes while the lock is set. A rejected write leaves every register unchanged.

Top module: `arb_cfg_regs`

## Requirements
- R1: After reset, master m's priority field holds the value m, the control register holds all zeros, and `rsp_valid` is low.
- R2: The priority register sits at byte offset 0x0. Master m's 3-bit field occupies bits 4m+2..4m, 000 is the highest priority and 111 the lowest, and the remaining bits read as zero. An accepted write updates `prio_out` (master m at bits 3m+2..3m) from the next cycle on.
- R3: Each cycle with `bus_rd` or `bus_wr` high produces exactly one `rsp_valid` pulse in the following cycle. `rsp_err` is only high with `rsp_valid`, and `rsp_rdata` is zero whenever the response carries an error or answers a write.
- R4: A priority write that would give two masters the same level returns an error, and the priority register keeps its previous value.
- R5: An access with `bus_super` low returns an error to any register, with read data zero, and changes nothing.
- R6: An access whose `bus_size` is not 2'b10 (32-bit) returns an error and changes nothing. The other codes are 2'b00 for 8-bit and 2'b01 for 16-bit.
- R7: The control register sits at byte offset 0x4. Bit 31 is the lock, bit 30 is the halt-low-priority flag, bits 5..4 are the parking mode (00 park on the named master, 01 park on the last master, 10 low-power park), and bits 1..0 name the park master. An accepted write drives `lock`, `halt_low`, `park_mode` and `park_master`.
- R8: A control write with parking mode 11 returns an error and leaves the control register unchanged.
- R9: Writing 0 to the lock bit is accepted any number of times. Once a 1 has been written, the lock stays set until reset.
- R10: While the lock is set, reads of both registers still return their contents without error, and every write returns an error and changes nothing.
- R11: An access to any offset other than 0x0 or 0x4, or a cycle with `bus_rd` and `bus_wr` both high, returns an error and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 4 | Byte offset of the access |
| bus_wdata | input | 32 | Write data |
| bus_size | input | 2 | Access width code: 00 8-bit, 01 16-bit, 10 32-bit |
| bus_super | input | 1 | High for a supervisor-mode access |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| rsp_valid | output | 1 | Response pulse, one cycle after the strobe |
| rsp_rdata | output | 32 | Read data of the response |
| rsp_err | output | 1 | Error flag of the response |
| prio_out | output | 12 | Priority level per master, 3 bits each |
| lock | output | 1 | Register lock state |
| halt_low | output | 1 | Halt request ranks lowest for initial arbitration |
| park_mode | output | 2 | Parking mode |
| park_master | output | 2 | Master to park on |

## Verification
A wrong priority or control state shows up on `prio_out` and the control pins in the cycle after the write edge. A read-back through the bus shows it one cycle after the read strobe. A flaw in the legality checks shows up in the response to the offending write, as a missing or a spurious `rsp_err`. A read that follows shows whether state changed when it should not have, so the bench reads back after every rejected write. A lock that clears too early, or does not stick, only becomes visible on the next write, so the bench writes several times while locked.

// File: rtl/arb_cfg_pkg.sv
package arb_cfg_pkg;
  localparam int PRIO_W       = 3;
  localparam int FIELD_STRIDE = 4;
  localparam int DATA_W       = 32;

  typedef enum logic [1:0] {
    PARK_FIXED = 2'b00,
    PARK_LAST  = 2'b01,
    PARK_LOWPW = 2'b10,
    PARK_RSVD  = 2'b11
  } park_mode_e;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } acc_size_e;

  localparam logic [3:0] OFS_PRIO = 4'h0;
  localparam logic [3:0] OFS_CTRL = 4'h4;
endpackage

// File: rtl/arb_cfg_decode.sv
module arb_cfg_decode
  import arb_cfg_pkg::*;
#(
  parameter int ADDR_W = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        size,
  input  logic              super_mode,
  input  logic              rd,
  input  logic              wr,
  output logic              sel_prio,
  output logic              sel_ctrl,
  output logic              rule_ok
);
  always_comb begin
    sel_prio = (addr == ADDR_W'(OFS_PRIO));
    sel_ctrl = (addr == ADDR_W'(OFS_CTRL));
    rule_ok  = super_mode && (size == SZ_WORD) && (sel_prio || sel_ctrl) && !(rd && wr);
  end
endmodule

// File: rtl/arb_prio_bank.sv
module arb_prio_bank
  import arb_cfg_pkg::*;
#(
  parameter int NUM_M = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [DATA_W-1:0]       wdata,
  output logic                    dup_found,
  output logic [NUM_M*PRIO_W-1:0] prio_flat,
  output logic [DATA_W-1:0]       rdata
);
  logic [PRIO_W-1:0] prio_q [NUM_M];
  logic [PRIO_W-1:0] cand   [NUM_M];

  for (genvar m = 0; m < NUM_M; m++) begin : g_field
    assign cand[m] = wdata[m*FIELD_STRIDE +: PRIO_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     prio_q[m] <= PRIO_W'(m);
      else if (wr_en) prio_q[m] <= cand[m];
    end

    assign prio_flat[m*PRIO_W +: PRIO_W] = prio_q[m];
  end

  always_comb begin
    dup_found = 1'b0;
    for (int i = 0; i < NUM_M; i++)
      for (int j = i + 1; j < NUM_M; j++)
        if (cand[i] == cand[j]) dup_found = 1'b1;
  end

  always_comb begin
    rdata = '0;
    for (int m = 0; m < NUM_M; m++)
      rdata[m*FIELD_STRIDE +: PRIO_W] = prio_q[m];
  end

  for (genvar i = 0; i < NUM_M; i++) begin : g_ui
    for (genvar j = i + 1; j < NUM_M; j++) begin : g_uj
      p_unique_levels_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prio_q[i] != prio_q[j]);
    end
  end
endmodule

// File: rtl/arb_ctrl_bank.sv
module arb_ctrl_bank
  import arb_cfg_pkg::*;
#(
  parameter int NUM_M = 4,
  localparam int MW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wdata,
  output logic              bad_value,
  output logic              lock_q,
  output logic              halt_q,
  output park_mode_e        mode_q,
  output logic [MW-1:0]     master_q,
  output logic [DATA_W-1:0] rdata
);
  park_mode_e    mode_in;
  logic [MW-1:0] master_in;

  assign mode_in   = park_mode_e'(wdata[5:4]);
  assign master_in = wdata[MW-1:0];
  assign bad_value = (mode_in == PARK_RSVD) || (32'(master_in) >= NUM_M);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lock_q   <= 1'b0;
      halt_q   <= 1'b0;
      mode_q   <= PARK_FIXED;
      master_q <= '0;
    end else if (wr_en) begin
      lock_q   <= wdata[31];
      halt_q   <= wdata[30];
      mode_q   <= mode_in;
      master_q <= master_in;
    end
  end

  always_comb begin
    rdata            = '0;
    rdata[31]        = lock_q;
    rdata[30]        = halt_q;
    rdata[5:4]       = mode_q;
    rdata[MW-1:0]    = master_q;
  end

  p_lock_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    lock_q |=> lock_q);
  p_mode_legal_r8: assert property (@(posedge clk) disable iff (!rst_n)
    mode_q != PARK_RSVD);
endmodule

// File: rtl/arb_cfg_regs.sv
module arb_cfg_regs
  import arb_cfg_pkg::*;
#(
  parameter int NUM_M  = 4,
  parameter int ADDR_W = 4,
  localparam int MW = (NUM_M > 1) ? $clog2(NUM_M) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [DATA_W-1:0]       bus_wdata,
  input  logic [1:0]              bus_size,
  input  logic                    bus_super,
  input  logic                    bus_rd,
  input  logic                    bus_wr,
  output logic                    rsp_valid,
  output logic [DATA_W-1:0]       rsp_rdata,
  output logic                    rsp_err,
  output logic [NUM_M*PRIO_W-1:0] prio_out,
  output logic                    lock,
  output logic                    halt_low,
  output logic [1:0]              park_mode,
  output logic [MW-1:0]           park_master
);
  logic              sel_prio, sel_ctrl, rule_ok;
  logic              dup_found, bad_value;
  logic              access, legal, wr_prio, wr_ctrl;
  logic [DATA_W-1:0] prio_rd, ctrl_rd;
  park_mode_e        mode_q;

  arb_cfg_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(bus_addr), .size(bus_size), .super_mode(bus_super),
    .rd(bus_rd), .wr(bus_wr),
    .sel_prio(sel_prio), .sel_ctrl(sel_ctrl), .rule_ok(rule_ok)
  );

  always_comb begin
    access  = bus_rd || bus_wr;
    legal   = rule_ok && !(bus_wr && (lock || (sel_prio && dup_found) || (sel_ctrl && bad_value)));
    wr_prio = bus_wr && legal && sel_prio;
    wr_ctrl = bus_wr && legal && sel_ctrl;
  end

  arb_prio_bank #(.NUM_M(NUM_M)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_prio), .wdata(bus_wdata),
    .dup_found(dup_found), .prio_flat(prio_out), .rdata(prio_rd)
  );

  arb_ctrl_bank #(.NUM_M(NUM_M)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_ctrl), .wdata(bus_wdata),
    .bad_value(bad_value), .lock_q(lock), .halt_q(halt_low),
    .mode_q(mode_q), .master_q(park_master), .rdata(ctrl_rd)
  );

  assign park_mode = mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= access;
      rsp_err   <= access && !legal;
      rsp_rdata <= (bus_rd && legal) ? (sel_prio ? prio_rd : ctrl_rd) : '0;
    end
  end

  p_err_in_rsp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);
  p_rsp_follows_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) |=> rsp_valid);
  p_locked_frozen_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lock && bus_wr) |=> ($stable(prio_out) && $stable(halt_low) && $stable(park_mode) && $stable(park_master)));
  p_user_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && !bus_super) |=> ($stable(prio_out) && $stable(lock) && $stable(park_mode)));
endmodule

// File: tb/test_arb_cfg_regs.sv
module test_arb_cfg_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [1:0]  bus_size = 2'b10;
  logic        bus_super = 1'b1;
  logic        bus_rd = 1'b0;
  logic        bus_wr = 1'b0;
  logic        rsp_valid, rsp_err, lock, halt_low;
  logic [31:0] rsp_rdata;
  logic [11:0] prio_out;
  logic [1:0]  park_mode, park_master;

  int total = 0;
  int bad = 0;
  logic        got_err;
  logic [31:0] got_data;

  always #10 clk = ~clk;

  arb_cfg_regs i_arb_cfg_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_size(bus_size), .bus_super(bus_super), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .prio_out(prio_out), .lock(lock), .halt_low(halt_low),
    .park_mode(park_mode), .park_master(park_master)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic access(input logic [3:0] a, input logic [31:0] d, input logic [1:0] sz,
                        input logic sup, input logic rd, input logic wr);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_size = sz; bus_super = sup; bus_rd = rd; bus_wr = wr;
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
    check("R3 rsp_valid", {31'b0, rsp_valid}, 32'd1);
    got_err  = rsp_err;
    got_data = rsp_rdata;
  endtask

  task automatic do_reset;
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic t_reset;
    do_reset();
    check("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    check("R1 prio_out", {20'b0, prio_out}, {20'b0, 3'd3, 3'd2, 3'd1, 3'd0});
    check("R1 ctrl pins", {27'b0, lock, halt_low, park_mode, park_master}, 32'd0);
    access(4'h0, 0, 2'b10, 1, 1, 0);
    check("R2 reset read", got_data, 32'h0000_3210);
    access(4'h4, 0, 2'b10, 1, 1, 0);
    check("R1 ctrl read", got_data, 32'h0);
    check("R1 ctrl read err", {31'b0, got_err}, 32'd0);
  endtask

  task automatic t_prio_write;
    access(4'h0, 32'hFFFF_0123, 2'b10, 1, 0, 1);
    check("R2 write err", {31'b0, got_err}, 32'd0);
    check("R3 write rdata", got_data, 32'd0);
    check("R2 prio_out", {20'b0, prio_out}, {20'b0, 3'd0, 3'd1, 3'd2, 3'd3});
    access(4'h0, 0, 2'b10, 1, 1, 0);
    check("R2 readback", got_data, 32'h0000_0123);
    @(negedge clk);
    check("R3 idle no rsp", {31'b0, rsp_valid}, 32'd0);
  endtask

  task automatic t_dup;
    access(4'h0, 32'h0000_1100, 2'b10, 1, 0, 1);
    check("R4 dup err", {31'b0, got_err}, 32'd1);
    check("R4 prio_out kept", {20'b0, prio_out}, {20'b0, 3'd0, 3'd1, 3'd2, 3'd3});
    access(4'h0, 32'h0000_2720, 2'b10, 1, 0, 1);
    check("R4 dup 3 err", {31'b0, got_err}, 32'd1);
    access(4'h0, 0, 2'b10, 1, 1, 0);
    check("R4 readback", got_data, 32'h0000_0123);
  endtask

  task automatic t_user;
    access(4'h0, 32'h0000_3210, 2'b10, 0, 0, 1);
    check("R5 user write err", {31'b0, got_err}, 32'd1);
    access(4'h0, 0, 2'b10, 0, 1, 0);
    check("R5 user read err", {31'b0, got_err}, 32'd1);
    check("R5 user read data", got_data, 32'd0);
    access(4'h4, 32'h4000_0001, 2'b10, 0, 0, 1);
    check("R5 user ctrl unchanged", {30'b0, park_master}, 32'd0);
    access(4'h0, 0, 2'b10, 1, 1, 0);
    check("R5 readback", got_data, 32'h0000_0123);
  endtask

  task automatic t_size;
    access(4'h0, 32'h0000_3210, 2'b00, 1, 0, 1);
    check("R6 byte err", {31'b0, got_err}, 32'd1);
    access(4'h0, 32'h0000_3210, 2'b01, 1, 0, 1);
    check("R6 half err", {31'b0, got_err}, 32'd1);
    access(4'h0, 0, 2'b01, 1, 1, 0);
    check("R6 half read err", {31'b0, got_err}, 32'd1);
    check("R6 prio_out kept", {20'b0, prio_out}, {20'b0, 3'd0, 3'd1, 3'd2, 3'd3});
  endtask

  task automatic t_ctrl;
    access(4'h4, 32'h4000_0013, 2'b10, 1, 0, 1);
    check("R7 ctrl write err", {31'b0, got_err}, 32'd0);
    check("R7 pins", {27'b0, lock, halt_low, park_mode, park_master}, {27'b0, 1'b0, 1'b1, 2'b01, 2'b11});
    access(4'h4, 0, 2'b10, 1, 1, 0);
    check("R7 readback", got_data, 32'h4000_0013);
    access(4'h4, 32'h0000_0030, 2'b10, 1, 0, 1);
    check("R8 mode 11 err", {31'b0, got_err}, 32'd1);
    check("R8 pins kept", {27'b0, lock, halt_low, park_mode, park_master}, {27'b0, 1'b0, 1'b1, 2'b01, 2'b11});
  endtask

  task automatic t_lock;
    access(4'h4, 32'h0000_0022, 2'b10, 1, 0, 1);
    check("R9 lock0 write a", {31'b0, got_err}, 32'd0);
    access(4'h4, 32'h0000_0021, 2'b10, 1, 0, 1);
    check("R9 lock0 write b", {31'b0, got_err}, 32'd0);
    check("R9 pins", {27'b0, lock, halt_low, park_mode, park_master}, {27'b0, 1'b0, 1'b0, 2'b10, 2'b01});
    access(4'h4, 32'h8000_0001, 2'b10, 1, 0, 1);
    check("R9 lock set", {31'b0, lock}, 32'd1);
    access(4'h4, 32'h0000_0000, 2'b10, 1, 0, 1);
    check("R10 locked ctrl err", {31'b0, got_err}, 32'd1);
    check("R9 lock held", {31'b0, lock}, 32'd1);
    access(4'h4, 0, 2'b10, 1, 1, 0);
    check("R10 locked read ok", {31'b0, got_err}, 32'd0);
    check("R10 ctrl readback", got_data, 32'h8000_0001);
    access(4'h0, 32'h0000_3210, 2'b10, 1, 0, 1);
    check("R10 locked prio err", {31'b0, got_err}, 32'd1);
    access(4'h0, 0, 2'b10, 1, 1, 0);
    check("R10 prio readback", got_data, 32'h0000_0123);
    do_reset();
    check("R9 reset clears lock", {31'b0, lock}, 32'd0);
    access(4'h0, 32'h0000_0312, 2'b10, 1, 0, 1);
    check("R9 write after reset", {31'b0, got_err}, 32'd0);
  endtask

  task automatic t_misc;
    access(4'h8, 0, 2'b10, 1, 1, 0);
    check("R11 unmapped err", {31'b0, got_err}, 32'd1);
    check("R11 unmapped data", got_data, 32'd0);
    access(4'h0, 32'h0000_3210, 2'b10, 1, 1, 1);
    check("R11 rd+wr err", {31'b0, got_err}, 32'd1);
    check("R11 prio kept", {20'b0, prio_out}, {20'b0, 3'd0, 3'd3, 3'd1, 3'd2});
  endtask

  initial begin
    t_reset();
    t_prio_write();
    t_dup();
    t_user();
    t_size();
    t_ctrl();
    t_lock();
    t_misc();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule